// File: doc/BRIEF.md
# Headroom-Managed Stereo Two-Input Mixer

This block combines two stereo streams of signed 24-bit samples, one coming from the record path and one from the serial playback input. Each source branch has its own volume and mute. When mixing is enabled, both branch results are halved before they are added, so two full-scale signals cannot overflow the adder. The sum then passes through a master volume and mute. After the master stage it is doubled again, and that doubling saturates at the 24-bit limits. When mixing is disabled, only the playback branch reaches the master stage and neither the halving nor the doubling is applied.

A sample pair is taken in only in a cycle where both source strobes are high. In that cycle all control inputs (gains, mutes, mix enable) are captured together with the data. The result leaves a fixed four-register pipeline with a single-cycle output strobe. Between strobes the output holds its value. Volumes are plain multipliers, so lowering the master gain is the way to keep the final doubling away from its clip points.

Top module: `audio_mix_core`

## Requirements
- R1: A sample is accepted only in a cycle where rec_valid_i and play_valid_i are both high. Exactly 4 rising edges after the accepting edge, out_valid_o is high for one cycle. Without acceptance, no strobe appears.
- R2: While rst_ni is low, out_valid_o, out_l_o and out_r_o are all 0.
- R3: A gain stage computes y = floor((x*g + 2^14) / 2^15), where g is an unsigned 16-bit value and 0x8000 is unity. The result saturates to the range [-2^23, 2^23-1].
- R4: A branch mute makes that branch's gain-stage output 0, whatever its gain.
- R5: With mix_en_i=1, the master stage input is floor(r/2) + floor(p/2), where r and p are the record and playback branch outputs (arithmetic shift right by 1).
- R6: With mix_en_i=1, the master stage output is doubled and saturates to [-2^23, 2^23-1].
- R7: With mix_en_i=0, the output equals the master gain applied to the playback branch output, with no halving or doubling. The record data and record controls have no effect.
- R8: The master mute forces both output channels to 0.
- R9: Control inputs are captured in the accepting cycle. out_l_o and out_r_o change only in cycles where out_valid_o is high.
- R10: The left and right channels are processed independently, using the same controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mix_en_i | input | 1 | 1: mix both sources; 0: playback only |
| rec_valid_i | input | 1 | Record sample strobe |
| rec_l_i | input | 24 | Record left sample, signed |
| rec_r_i | input | 24 | Record right sample, signed |
| play_valid_i | input | 1 | Playback sample strobe |
| play_l_i | input | 24 | Playback left sample, signed |
| play_r_i | input | 24 | Playback right sample, signed |
| rec_gain_i | input | 16 | Record branch gain, 0x8000 = unity |
| rec_mute_i | input | 1 | Record branch mute |
| play_gain_i | input | 16 | Playback branch gain, 0x8000 = unity |
| play_mute_i | input | 1 | Playback branch mute |
| mst_gain_i | input | 16 | Master gain, 0x8000 = unity |
| mst_mute_i | input | 1 | Master mute |
| out_valid_o | output | 1 | Output sample strobe |
| out_l_o | output | 24 | Mixed left sample, signed |
| out_r_o | output | 24 | Mixed right sample, signed |

## Verification
The bench builds the block with its defaults: 24-bit samples and 16-bit gains with unity at 0x8000. With these widths, full-scale data and gains near 0xFFFF can be reached directly, so the saturation of the branch gain, the master gain and the final doubling can all be provoked. Random gains spread across the whole 16-bit range exercise rounding on both sides of zero. Strobe patterns where only one source is valid, together with back-to-back accepted samples, test the acceptance rule and the hold behaviour between output strobes.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned PIPE_LAT = 4;
endpackage

// File: rtl/mix_gain.sv
module mix_gain #(
  parameter int unsigned DW = 24,
  parameter int unsigned GW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] x_i,
  input  logic        [GW-1:0] g_i,
  input  logic                 mute_i,
  output logic signed [DW-1:0] y_o
);
  localparam int unsigned PW   = DW + GW + 1;
  localparam int unsigned FRAC = GW - 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;
  localparam logic signed [PW-1:0] HALF = {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic [GW-1:0] UNITY = {1'b1, {(GW-1){1'b0}}};

  logic signed [PW-1:0] x_ext, g_ext, prod, rnd, shr;
  logic signed [DW-1:0] sat_y;

  assign x_ext = PW'(x_i);
  assign g_ext = $signed({{(PW-GW){1'b0}}, g_i});
  assign prod  = x_ext * g_ext;
  assign rnd   = prod + HALF;
  assign shr   = rnd >>> FRAC;

  always_comb begin
    if (shr > MAXV)      sat_y = MAXV[DW-1:0];
    else if (shr < MINV) sat_y = MINV[DW-1:0];
    else                 sat_y = shr[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_o <= '0;
    else if (en_i)   y_o <= mute_i ? '0 : sat_y;
  end

  assert_mute_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mute_i |=> y_o == '0);
  assert_unity_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !mute_i && g_i == UNITY |=> y_o == $past(x_i));
  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(y_o));
endmodule

// File: rtl/mix_sum.sv
module mix_sum #(
  parameter int unsigned DW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 mix_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] s_o
);
  logic signed [DW:0] a_h, b_h, tot;

  // 6 dB pre-attenuation on both operands keeps the sum inside DW bits
  assign a_h = $signed({a_i[DW-1], a_i}) >>> 1;
  assign b_h = $signed({b_i[DW-1], b_i}) >>> 1;
  assign tot = a_h + b_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   s_o <= '0;
    else if (en_i) s_o <= mix_i ? tot[DW-1:0] : b_i;
  end

  assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !mix_i |=> s_o == $past(b_i));
  assert_both_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mix_i && a_i == '0 && b_i == '0 |=> s_o == '0);
endmodule

// File: rtl/mix_restore.sv
module mix_restore #(
  parameter int unsigned DW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 mix_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] QTR  = {2'b01, {(DW-2){1'b0}}};

  logic [DW:0]          dbl;
  logic signed [DW-1:0] up;

  assign dbl = {x_i, 1'b0};
  always_comb begin
    if (dbl[DW] != dbl[DW-1]) up = dbl[DW] ? MINV : MAXV;
    else                      up = dbl[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= mix_i ? up : x_i;
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mix_i && x_i >= QTR |=> y_o == MAXV);
  assert_sign_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mix_i |=> y_o[DW-1] == $past(x_i[DW-1]));
endmodule

// File: rtl/audio_mix_core.sv
module audio_mix_core #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mix_en_i,
  input  logic              rec_valid_i,
  input  logic [DATA_W-1:0] rec_l_i,
  input  logic [DATA_W-1:0] rec_r_i,
  input  logic              play_valid_i,
  input  logic [DATA_W-1:0] play_l_i,
  input  logic [DATA_W-1:0] play_r_i,
  input  logic [GAIN_W-1:0] rec_gain_i,
  input  logic              rec_mute_i,
  input  logic [GAIN_W-1:0] play_gain_i,
  input  logic              play_mute_i,
  input  logic [GAIN_W-1:0] mst_gain_i,
  input  logic              mst_mute_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_l_o,
  output logic [DATA_W-1:0] out_r_o
);
  import mix_pkg::*;

  logic acc;
  logic v1, v2, v3;
  logic mix1, mix2, mix3;
  logic [GAIN_W-1:0] mg1;
  logic mm1;

  logic signed [DATA_W-1:0] rec_in  [NUM_CH];
  logic signed [DATA_W-1:0] play_in [NUM_CH];
  logic signed [DATA_W-1:0] rec_g   [NUM_CH];
  logic signed [DATA_W-1:0] play_g  [NUM_CH];
  logic signed [DATA_W-1:0] sum_q   [NUM_CH];
  logic signed [DATA_W-1:0] mst_q   [NUM_CH];
  logic signed [DATA_W-1:0] res_q   [NUM_CH];

  assign acc = rec_valid_i & play_valid_i;

  assign rec_in[0]  = rec_l_i;
  assign rec_in[1]  = rec_r_i;
  assign play_in[0] = play_l_i;
  assign play_in[1] = play_r_i;

  // controls travel with the sample they were captured for
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; out_valid_o <= 1'b0;
      mix1 <= 1'b0; mix2 <= 1'b0; mix3 <= 1'b0;
      mg1 <= '0; mm1 <= 1'b0;
    end else begin
      v1 <= acc; v2 <= v1; v3 <= v2; out_valid_o <= v3;
      if (acc) begin
        mix1 <= mix_en_i; mg1 <= mst_gain_i; mm1 <= mst_mute_i;
      end
      if (v1) mix2 <= mix1;
      if (v2) mix3 <= mix2;
    end
  end

  logic [GAIN_W-1:0] mg2;
  logic              mm2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mg2 <= '0; mm2 <= 1'b0;
    end else if (v1) begin
      mg2 <= mg1; mm2 <= mm1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mix_gain #(.DW(DATA_W), .GW(GAIN_W)) u_rec (
      .clk_i, .rst_ni, .en_i(acc), .x_i(rec_in[c]), .g_i(rec_gain_i),
      .mute_i(rec_mute_i), .y_o(rec_g[c]));
    mix_gain #(.DW(DATA_W), .GW(GAIN_W)) u_play (
      .clk_i, .rst_ni, .en_i(acc), .x_i(play_in[c]), .g_i(play_gain_i),
      .mute_i(play_mute_i), .y_o(play_g[c]));
    mix_sum #(.DW(DATA_W)) u_sum (
      .clk_i, .rst_ni, .en_i(v1), .mix_i(mix1), .a_i(rec_g[c]),
      .b_i(play_g[c]), .s_o(sum_q[c]));
    mix_gain #(.DW(DATA_W), .GW(GAIN_W)) u_mst (
      .clk_i, .rst_ni, .en_i(v2), .x_i(sum_q[c]), .g_i(mg2),
      .mute_i(mm2), .y_o(mst_q[c]));
    mix_restore #(.DW(DATA_W)) u_res (
      .clk_i, .rst_ni, .en_i(v3), .mix_i(mix3), .x_i(mst_q[c]), .y_o(res_q[c]));
  end

  assign out_l_o = res_q[0];
  assign out_r_o = res_q[1];

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> ##4 out_valid_o);
  assert_strobe_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !$past(v2) |=> !out_valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_l_o) && $stable(out_r_o));
  assert_reset_R2: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o && out_l_o == '0 && out_r_o == '0);
endmodule

// File: tb/sim_audio_mix_core.sv
`timescale 1ns/1ps
module sim_audio_mix_core;
  localparam int DW = 24;
  localparam int GW = 16;
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mix_en = 1'b0, rec_v = 1'b0, play_v = 1'b0;
  logic [DW-1:0] rec_l = '0, rec_r = '0, play_l = '0, play_r = '0;
  logic [GW-1:0] rec_g = '0, play_g = '0, mst_g = '0;
  logic rec_m = 1'b0, play_m = 1'b0, mst_m = 1'b0;
  logic out_v;
  logic [DW-1:0] out_l, out_r;

  always #2 clk = ~clk;

  audio_mix_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .mix_en_i(mix_en),
    .rec_valid_i(rec_v), .rec_l_i(rec_l), .rec_r_i(rec_r),
    .play_valid_i(play_v), .play_l_i(play_l), .play_r_i(play_r),
    .rec_gain_i(rec_g), .rec_mute_i(rec_m),
    .play_gain_i(play_g), .play_mute_i(play_m),
    .mst_gain_i(mst_g), .mst_mute_i(mst_m),
    .out_valid_o(out_v), .out_l_o(out_l), .out_r_o(out_r));

  int checks = 0, fails = 0;
  bit done = 0;

  logic   pv [4];
  longint pl [4];
  longint pr [4];
  string  pt [4];
  longint last_l = 0, last_r = 0;

  function automatic longint sat(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint gain(longint x, longint g, bit m);
    if (m) return 0;
    return sat((x * g + 16384) >>> 15);
  endfunction

  function automatic longint model(longint r, longint p, bit mx,
      longint rg, bit rm, longint pg, bit pm, longint mg, bit mm);
    longint a, b, s;
    a = gain(r, rg, rm);
    b = gain(p, pg, pm);
    if (mx) begin
      s = (a >>> 1) + (b >>> 1);
      return sat(gain(s, mg, mm) * 2);
    end
    return gain(b, mg, mm);
  endfunction

  function automatic longint sx(logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // samples at negedge, then drives next inputs and advances one cycle
  task automatic step(bit rv, bit pvv, bit mx, longint rl, longint rr,
      longint ppl, longint ppr, int rgv, bit rmv, int pgv, bit pmv,
      int mgv, bit mmv, string tag);
    check(pv[3] ? pt[3] : "R1", longint'(out_v), longint'(pv[3]));
    if (pv[3]) begin
      check({pt[3], "/R10 left"}, sx(out_l), pl[3]);
      check({pt[3], "/R10 right"}, sx(out_r), pr[3]);
      last_l = pl[3]; last_r = pr[3];
    end else begin
      check("R9 hold left", sx(out_l), last_l);
      check("R9 hold right", sx(out_r), last_r);
    end
    rec_v = rv; play_v = pvv; mix_en = mx;
    rec_l = DW'(rl); rec_r = DW'(rr); play_l = DW'(ppl); play_r = DW'(ppr);
    rec_g = GW'(rgv); rec_m = rmv; play_g = GW'(pgv); play_m = pmv;
    mst_g = GW'(mgv); mst_m = mmv;
    @(posedge clk);
    for (int i = 3; i > 0; i--) begin
      pv[i] = pv[i-1]; pl[i] = pl[i-1]; pr[i] = pr[i-1]; pt[i] = pt[i-1];
    end
    pv[0] = rv & pvv;
    pl[0] = model(sx(DW'(rl)), sx(DW'(ppl)), mx, rgv, rmv, pgv, pmv, mgv, mmv);
    pr[0] = model(sx(DW'(rr)), sx(DW'(ppr)), mx, rgv, rmv, pgv, pmv, mgv, mmv);
    pt[0] = tag;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin pv[i] = 0; pl[i] = 0; pr[i] = 0; pt[i] = "R1"; end
    void'($urandom(32'd1342));
    repeat (3) @(negedge clk);
    check("R2 valid", longint'(out_v), 0);
    check("R2 left", sx(out_l), 0);
    check("R2 right", sx(out_r), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // unity everywhere, playback only
    step(1, 1, 0, 111, -222, 1000, -1000, 32768, 0, 32768, 0, 32768, 0, "R3 R7 unity");
    // rounding around zero and half gain
    step(1, 1, 0, 0, 0, -3, 3, 32768, 0, 16384, 0, 32768, 0, "R3 round");
    // gain overflow saturates
    step(1, 1, 0, 0, 0, MAXV, MINV, 0, 0, 65535, 0, 32768, 0, "R3 sat");
    // record ignored when mixing is off
    step(1, 1, 0, MAXV, MINV, 500, -7, 65535, 0, 32768, 0, 32768, 0, "R7 rec ignored");
    // full-scale mix saturates after restore
    step(1, 1, 1, MAXV, MAXV, MAXV, MAXV, 32768, 0, 32768, 0, 32768, 0, "R6 clip hi");
    step(1, 1, 1, MINV, MINV, MINV, MINV, 32768, 0, 32768, 0, 65535, 0, "R6 clip lo");
    // odd values: floor on halving
    step(1, 1, 1, 3, -3, 5, -5, 32768, 0, 32768, 0, 32768, 0, "R5 halving");
    // record mute
    step(1, 1, 1, 4000, 4000, 100, 100, 32768, 1, 32768, 0, 32768, 0, "R4 rec mute");
    step(1, 1, 1, 4000, 4000, 100, 100, 32768, 0, 40000, 1, 32768, 0, "R4 play mute");
    step(1, 1, 1, 4000, 4000, 100, 100, 32768, 0, 32768, 0, 32768, 1, "R8 master mute");
    // only one strobe: nothing accepted
    step(1, 0, 1, 9, 9, 9, 9, 32768, 0, 32768, 0, 32768, 0, "R1 rec only");
    step(0, 1, 1, 9, 9, 9, 9, 32768, 0, 32768, 0, 32768, 0, "R1 play only");
    repeat (5) idle();
    // controls captured at acceptance, changed while sample in flight
    step(1, 1, 1, 1000, 2000, 3000, 4000, 32768, 0, 32768, 0, 16384, 0, "R9 capture");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, "R9 capture");
    repeat (5) idle();

    for (int n = 0; n < 800; n++) begin
      bit rv, pvv, mx, rm, pm, mm;
      int rgv, pgv, mgv;
      rv  = ($urandom_range(0, 9) != 0);
      pvv = ($urandom_range(0, 9) != 0);
      mx  = $urandom_range(0, 1);
      rm  = ($urandom_range(0, 7) == 0);
      pm  = ($urandom_range(0, 7) == 0);
      mm  = ($urandom_range(0, 7) == 0);
      rgv = $urandom_range(0, 65535);
      pgv = $urandom_range(0, 65535);
      mgv = $urandom_range(0, 65535);
      step(rv, pvv, mx, sx(DW'($urandom)), sx(DW'($urandom)),
           sx(DW'($urandom)), sx(DW'($urandom)), rgv, rm, pgv, pm, mgv, mm,
           mx ? "R5 R6 random" : "R7 random");
    end
    repeat (5) idle();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule